// File: doc/BRIEF.md
# Secondary Configuration Type Converter with Private Device Hiding

This block sits on the downstream face of a PCI-to-PCI bridge. It takes an upstream Type 1 configuration request whose bus, device, function and register fields are already decoded. When the request names the bridge's own secondary bus, the block builds the Type 0 address-phase word for that bus. The word carries a one-hot IDSEL pattern on the upper address lines. A request for any other bus number leaves as an unchanged Type 1 word, so a downstream bridge can claim it.

A private device mask is captured from strap pins while reset is asserted. Any secondary device whose bit is set in the mask is hidden from system software. A configuration access to a hidden device is steered to the reserved slot 15, whose IDSEL line is address bit 31. Secondary boards that use this feature leave slot 15 unpopulated, so the access ends in master abort. Only a fixed subset of device numbers can be hidden. Device numbers 16 to 31 assert no IDSEL line at all.

The output word and its type flag are registered. A valid output appears one clock after a valid request.

Top module: `cfg_type_convert`

## Requirements
- R1: For a request with busNum equal to secBusNum, a device number n in 0..15 and n not hidden, the output is Type 0 (outIsType0=1), and among outAddr[31:16] only bit 16+n is 1.
- R2: In every Type 0 output, outAddr[10:8] equals funcNum, outAddr[7:2] equals regNum, outAddr[1:0] is 00 and outAddr[15:11] is zero.
- R3: For a local request to a device whose privMask bit is 1, outAddr[31:16] is exactly 16'h8000, meaning slot 15 is selected. Function and register fields are kept as in R2.
- R4: Only device numbers 1, 4, 5, 6, 7, 9 and 13 can be hidden, and privMask bit n stands for device n. The other privMask bits always read 0, whatever the strap value.
- R5: While rstN is low, privMask is loaded on each clock from maskStrap, filtered as in R4. Once rstN is high, privMask holds, and strap changes have no effect on privMask or on redirection.
- R6: When busNum differs from secBusNum, the output is Type 1 (outIsType0=0) and carries the following fields:
  - outAddr[31:24] = 0
  - outAddr[23:16] = busNum
  - outAddr[15:11] = devNum
  - outAddr[10:8] = funcNum
  - outAddr[7:2] = regNum
  - outAddr[1:0] = 01
- R7: A local request to a device number in 16..31 gives a Type 0 output with outAddr[31:16] all zero.
- R8: outValid is 1 exactly one clock after a clock with reqValid=1 and is 0 otherwise. During reset, outValid, outIsType0 and outAddr are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; the strap is captured while it is low |
| reqValid | input | 1 | Request fields are valid this cycle |
| busNum | input | 8 | Target bus number of the Type 1 request |
| devNum | input | 5 | Target device number |
| funcNum | input | 3 | Target function number |
| regNum | input | 6 | Dword register number |
| secBusNum | input | 8 | Secondary bus number of this bridge |
| maskStrap | input | 16 | Strap value for the private device mask |
| privMask | output | 16 | Captured private device mask, bit n for device n |
| outValid | output | 1 | Address-phase word valid |
| outIsType0 | output | 1 | 1 for a Type 0 word, 0 for a Type 1 pass-through |
| outAddr | output | 32 | Secondary address-phase word |

## Verification
The assertions check several properties on every cycle:
- at most one IDSEL line is asserted in any Type 0 word, and its low two bits are zero;
- a hidden local target always yields the slot-15 pattern;
- a foreign bus always leaves as Type 1;
- output validity follows request validity by one clock;
- the mask never moves while reset is high.

Only the bench scenarios can show that the exact IDSEL bit for each device number and the field placement are correct. The same holds for the capture of a different strap across a second reset, and for the rule that non-maskable strap bits are discarded.

// File: rtl/cfgconv_pkg.sv
package cfgconv_pkg;
  parameter int ADDR_W      = 32;
  parameter int BUS_W       = 8;
  parameter int DEV_W       = 5;
  parameter int FUNC_W      = 3;
  parameter int REG_W       = 6;
  parameter int NUM_SLOTS   = 16;
  parameter int IDSEL_LSB   = 16;
  parameter int SLOT_W      = $clog2(NUM_SLOTS);
  parameter int REDIRECT_SLOT = NUM_SLOTS - 1;
  parameter logic [NUM_SLOTS-1:0] HIDEABLE_SET = 16'h22F2;

  parameter int REG_LSB  = 2;
  parameter int FUNC_LSB = REG_LSB + REG_W;
  parameter int DEV_LSB  = FUNC_LSB + FUNC_W;
  parameter int BUS_LSB  = DEV_LSB + DEV_W;

  typedef struct packed {
    logic                load;
    logic                toType0;
    logic                idselEn;
    logic [SLOT_W-1:0]   slot;
  } ctrlStrobeT;
endpackage

// File: rtl/cfgconv_mask.sv
module cfgconv_mask
  import cfgconv_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SLOTS-1:0] strapIn,
  output logic [NUM_SLOTS-1:0] maskOut
);
  logic [NUM_SLOTS-1:0] maskQ;
  logic [NUM_SLOTS-1:0] strapFilt;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_filt
    if (HIDEABLE_SET[i]) begin : g_keep
      assign strapFilt[i] = strapIn[i];
    end else begin : g_zero
      assign strapFilt[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) maskQ <= strapFilt;
  end

  assign maskOut = maskQ;
endmodule

// File: rtl/cfgconv_ctrl.sv
module cfgconv_ctrl
  import cfgconv_pkg::*;
(
  input  logic                 reqValid,
  input  logic [BUS_W-1:0]     busNum,
  input  logic [DEV_W-1:0]     devNum,
  input  logic [BUS_W-1:0]     secBusNum,
  input  logic [NUM_SLOTS-1:0] hideMask,
  output ctrlStrobeT           strobe
);
  localparam int HI_W = DEV_W - SLOT_W;

  logic              isLocal;
  logic              inSlotRange;
  logic [SLOT_W-1:0] devSlot;
  logic              isHidden;

  assign isLocal     = (busNum == secBusNum);
  assign inSlotRange = (devNum[DEV_W-1 -: HI_W] == '0);
  assign devSlot     = devNum[SLOT_W-1:0];
  assign isHidden    = inSlotRange && hideMask[devSlot];

  always_comb begin
    strobe.load    = reqValid;
    strobe.toType0 = isLocal;
    strobe.idselEn = isLocal && inSlotRange;
    strobe.slot    = isHidden ? SLOT_W'(REDIRECT_SLOT) : devSlot;
  end
endmodule

// File: rtl/cfgconv_dpath.sv
module cfgconv_dpath
  import cfgconv_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  logic [BUS_W-1:0]  busNum,
  input  logic [DEV_W-1:0]  devNum,
  input  logic [FUNC_W-1:0] funcNum,
  input  logic [REG_W-1:0]  regNum,
  output logic              outValid,
  output logic              outIsType0,
  output logic [ADDR_W-1:0] outAddr
);
  logic [NUM_SLOTS-1:0] idselVec;
  logic [ADDR_W-1:0]    type0Word;
  logic [ADDR_W-1:0]    type1Word;
  logic [ADDR_W-1:0]    nextWord;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_idsel
    assign idselVec[s] = strobe.idselEn && (strobe.slot == SLOT_W'(s));
  end

  always_comb begin
    type0Word = '0;
    type0Word[IDSEL_LSB +: NUM_SLOTS] = idselVec;
    type0Word[FUNC_LSB +: FUNC_W]     = funcNum;
    type0Word[REG_LSB +: REG_W]       = regNum;

    type1Word = '0;
    type1Word[BUS_LSB +: BUS_W]   = busNum;
    type1Word[DEV_LSB +: DEV_W]   = devNum;
    type1Word[FUNC_LSB +: FUNC_W] = funcNum;
    type1Word[REG_LSB +: REG_W]   = regNum;
    type1Word[1:0]                = 2'b01;

    nextWord = strobe.toType0 ? type0Word : type1Word;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outIsType0 <= 1'b0;
      outAddr    <= '0;
    end else begin
      outValid <= strobe.load;
      if (strobe.load) begin
        outIsType0 <= strobe.toType0;
        outAddr    <= nextWord;
      end
    end
  end
endmodule

// File: rtl/cfg_type_convert.sv
module cfg_type_convert
  import cfgconv_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [BUS_W-1:0]     busNum,
  input  logic [DEV_W-1:0]     devNum,
  input  logic [FUNC_W-1:0]    funcNum,
  input  logic [REG_W-1:0]     regNum,
  input  logic [BUS_W-1:0]     secBusNum,
  input  logic [NUM_SLOTS-1:0] maskStrap,
  output logic [NUM_SLOTS-1:0] privMask,
  output logic                 outValid,
  output logic                 outIsType0,
  output logic [ADDR_W-1:0]    outAddr
);
  ctrlStrobeT strobe;

  cfgconv_mask u_mask (
    .clk     (clk),
    .rstN    (rstN),
    .strapIn (maskStrap),
    .maskOut (privMask)
  );

  cfgconv_ctrl u_ctrl (
    .reqValid  (reqValid),
    .busNum    (busNum),
    .devNum    (devNum),
    .secBusNum (secBusNum),
    .hideMask  (privMask),
    .strobe    (strobe)
  );

  cfgconv_dpath u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .busNum     (busNum),
    .devNum     (devNum),
    .funcNum    (funcNum),
    .regNum     (regNum),
    .outValid   (outValid),
    .outIsType0 (outIsType0),
    .outAddr    (outAddr)
  );
endmodule

// File: rtl/cfg_type_convert_chk.sv
module cfg_type_convert_chk
  import cfgconv_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic [BUS_W-1:0]     busNum,
  input logic [DEV_W-1:0]     devNum,
  input logic [BUS_W-1:0]     secBusNum,
  input logic [NUM_SLOTS-1:0] privMask,
  input logic                 outValid,
  input logic                 outIsType0,
  input logic [ADDR_W-1:0]    outAddr
);
  p_onehot_idsel_r1: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outIsType0) |-> $onehot0(outAddr[IDSEL_LSB +: NUM_SLOTS]));

  p_type0_low_bits_r2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outIsType0) |-> (outAddr[1:0] == 2'b00));

  p_hidden_redirect_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && busNum == secBusNum && devNum < DEV_W'(NUM_SLOTS)
     && privMask[devNum[SLOT_W-1:0]])
    |=> (outValid && outIsType0
         && outAddr[IDSEL_LSB +: NUM_SLOTS] == (NUM_SLOTS'(1) << REDIRECT_SLOT)));

  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> $stable(privMask));

  p_foreign_type1_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && busNum != secBusNum)
    |=> (outValid && !outIsType0 && outAddr[1:0] == 2'b01));

  p_valid_follow_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> outValid);

  p_valid_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !outValid);
endmodule

bind cfg_type_convert cfg_type_convert_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .busNum     (busNum),
  .devNum     (devNum),
  .secBusNum  (secBusNum),
  .privMask   (privMask),
  .outValid   (outValid),
  .outIsType0 (outIsType0),
  .outAddr    (outAddr)
);

// File: tb/cfg_type_convert_tb.sv
module cfg_type_convert_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [7:0]  busNum = '0;
  logic [4:0]  devNum = '0;
  logic [2:0]  funcNum = '0;
  logic [5:0]  regNum = '0;
  logic [7:0]  secBusNum = 8'h05;
  logic [15:0] maskStrap = 16'hFFFF;
  logic [15:0] privMask;
  logic        outValid;
  logic        outIsType0;
  logic [31:0] outAddr;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  cfg_type_convert u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .busNum(busNum),
    .devNum(devNum), .funcNum(funcNum), .regNum(regNum),
    .secBusNum(secBusNum), .maskStrap(maskStrap), .privMask(privMask),
    .outValid(outValid), .outIsType0(outIsType0), .outAddr(outAddr)
  );

  typedef struct packed {
    logic [7:0]  bus;
    logic [4:0]  dev;
    logic [2:0]  fn;
    logic [5:0]  rg;
    logic [31:0] expAddr;
    logic        expT0;
  } vecT;

  // Expected words for secBusNum=5 and privMask=16'h22F2
  localparam int NV = 11;
  localparam vecT VECS [NV] = '{
    '{8'h05, 5'd0,  3'd0, 6'h00, 32'h0001_0000, 1'b1},  // R1
    '{8'h05, 5'd2,  3'd3, 6'h0A, 32'h0004_0328, 1'b1},  // R1 R2
    '{8'h05, 5'd4,  3'd1, 6'h01, 32'h8000_0104, 1'b1},  // R3
    '{8'h05, 5'd13, 3'd7, 6'h3F, 32'h8000_07FC, 1'b1},  // R3
    '{8'h05, 5'd15, 3'd0, 6'h02, 32'h8000_0008, 1'b1},  // R1
    '{8'h05, 5'd14, 3'd2, 6'h03, 32'h4000_020C, 1'b1},  // R1
    '{8'h05, 5'd20, 3'd1, 6'h05, 32'h0000_0114, 1'b1},  // R7
    '{8'h06, 5'd4,  3'd1, 6'h01, 32'h0006_2105, 1'b0},  // R6
    '{8'h20, 5'd31, 3'd7, 6'h3F, 32'h0020_FFFD, 1'b0},  // R6
    '{8'h05, 5'd3,  3'd5, 6'h07, 32'h0008_051C, 1'b1},  // R1 R2
    '{8'h05, 5'd8,  3'd0, 6'h00, 32'h0100_0000, 1'b1}   // R1
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sendReq(input logic [7:0] b, input logic [4:0] d,
                         input logic [2:0] f, input logic [5:0] r);
    @(negedge clk);
    busNum = b; devNum = d; funcNum = f; regNum = r; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic doReset(input logic [15:0] strap);
    @(negedge clk);
    maskStrap = strap;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 reset outValid", 32'(outValid), 32'd0);
    check("R8 reset outAddr", outAddr, 32'd0);
    check("R8 reset outIsType0", 32'(outIsType0), 32'd0);
    rstN = 1'b1;
    // R4 only hideable bits survive an all-ones strap
    check("R4 privMask filter", 32'(privMask), 32'h0000_22F2);

    for (int i = 0; i < NV; i++) begin
      sendReq(VECS[i].bus, VECS[i].dev, VECS[i].fn, VECS[i].rg);
      check($sformatf("R8 vec%0d valid", i), 32'(outValid), 32'd1);
      check($sformatf("R1 R2 R3 R6 R7 vec%0d addr", i), outAddr, VECS[i].expAddr);
      check($sformatf("R6 vec%0d type", i), 32'(outIsType0), 32'(VECS[i].expT0));
    end

    // R8 idle cycle after a request
    @(negedge clk);
    check("R8 idle outValid", 32'(outValid), 32'd0);

    // R5 strap change after reset has no effect
    maskStrap = 16'h0000;
    repeat (2) @(negedge clk);
    check("R5 mask held", 32'(privMask), 32'h0000_22F2);
    sendReq(8'h05, 5'd4, 3'd0, 6'h00);
    check("R5 still redirected", outAddr, 32'h8000_0000);

    // R5 new strap captured by a second reset; R4 dev3 not hideable
    doReset(16'h0018);
    check("R5 R4 new mask", 32'(privMask), 32'h0000_0010);
    sendReq(8'h05, 5'd4, 3'd0, 6'h00);
    check("R3 dev4 hidden", outAddr, 32'h8000_0000);
    sendReq(8'h05, 5'd5, 3'd0, 6'h00);
    check("R1 dev5 visible", outAddr, 32'h0020_0000);
    sendReq(8'h05, 5'd3, 3'd0, 6'h00);
    check("R4 dev3 not hideable", outAddr, 32'h0008_0000);

    // R6 secondary bus change turns a local request into pass-through
    secBusNum = 8'h07;
    sendReq(8'h05, 5'd1, 3'd2, 6'h04);
    check("R6 foreign addr", outAddr, 32'h0005_0A11);
    check("R6 foreign type", 32'(outIsType0), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule